// File: doc/BRIEF.md
# Extension Binding Lookup

This block resolves an interface binding request into a short routing handle. The caller supplies a key word that carries an interface identifier in its upper bits and a device sequence number in its lower bits. The block compares that pair against every entry of a small associative table at once. It returns one word that holds the handle bound to the pair, with the caller's payload bits packed above it. Later commands use that handle to reach the device that implements the interface.

The table is loaded through a configuration write port at reset or startup time. Each write names an entry slot and supplies an identifier, a sequence number, a handle and a valid flag. When no entry matches, the block returns handle 0, which is reserved to mean failure. It raises no fault. By convention, handles 1 and 2 name built-in fallback interfaces: one returns zero and the other returns minus one. Handles 3 to 7 are held for further fallbacks, 8 to 30 are error codes, and 31 is reserved. The table stores any handle value exactly as it was written.

Top module: `bind_lookup`

## Requirements
- R1: After reset, `rsp_valid` is 0 and every table entry is invalid, so every lookup returns handle 0 until the table is loaded.
- R2: The key word holds the device sequence number in bits [11:0] and the interface identifier in bits [31:12]. An entry matches only when it is valid and both fields are equal.
- R3: The result word holds the handle in bits [11:0] and `req_payload` (the low XLEN-12 bits of the second operand) in bits [XLEN-1:12].
- R4: When no valid entry matches, the handle field of the result is 0.
- R5: One identifier can be bound to different handles under different sequence numbers. For example, the identifier with sequence 0 gives handle 32, and with sequence 1 it gives handle 34.
- R6: When several valid entries match, the entry with the lowest index supplies the handle.
- R7: A configuration write takes effect at the clock edge where it is sampled. A lookup sampled at that same edge still sees the old table contents, and the next lookup sees the new ones.
- R8: A request sampled with `req_valid` high produces `rsp_valid` high exactly one cycle later. With no request, `rsp_valid` is low and `rsp_word` holds its last value.
- R9: Writing an entry with its valid flag at 0 removes it from matching.
- R10: Entry index 15, the last slot, behaves like any other slot and returns the full 12-bit handle value 12'hFFF verbatim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request qualifier |
| req_key | input | XLEN (32) | Identifier in [31:12], sequence number in [11:0] |
| req_payload | input | XLEN-12 (20) | Caller data packed above the handle |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | $clog2(ENTRIES) (4) | Entry slot to write |
| cfg_id | input | 20 | Identifier for the entry |
| cfg_seq | input | 12 | Sequence number for the entry |
| cfg_handle | input | 12 | Handle bound to the entry |
| cfg_valid | input | 1 | Valid flag written to the entry |
| rsp_valid | output | 1 | Result qualifier, one cycle after the request |
| rsp_word | output | XLEN (32) | Payload in [31:12], handle in [11:0] |

## Verification
Every lookup result is due exactly one cycle after the edge that samples its request. The driver task presents each request on a falling edge and queues the expected word. The monitor samples on later falling edges and pops one queued item for each cycle in which `rsp_valid` is high, so a result that arrives a cycle early or late shows up as a mismatch or as an unexpected or missing response. A configuration write is due at the edge that samples it. The bench therefore places one lookup in that same cycle, which must return the old handle, and one in the next cycle, which must return the new handle.

// File: rtl/bind_pkg.sv
package bind_pkg;
  localparam int XLEN_DEF    = 32;
  localparam int SEQ_W_DEF   = 12;
  localparam int HDL_W_DEF   = 12;
  localparam int ENTRIES_DEF = 16;
  localparam int HANDLE_MISS = 0;
endpackage

// File: rtl/bind_table.sv
module bind_table #(
  parameter int ENTRIES = bind_pkg::ENTRIES_DEF,
  parameter int ID_W    = 20,
  parameter int SEQ_W   = bind_pkg::SEQ_W_DEF,
  parameter int HDL_W   = bind_pkg::HDL_W_DEF,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [IDX_W-1:0]                idx,
  input  logic [ID_W-1:0]                 wr_id,
  input  logic [SEQ_W-1:0]                wr_seq,
  input  logic [HDL_W-1:0]                wr_handle,
  input  logic                            wr_valid,
  output logic [ENTRIES-1:0]              ent_valid,
  output logic [ENTRIES-1:0][ID_W-1:0]    ent_id,
  output logic [ENTRIES-1:0][SEQ_W-1:0]   ent_seq,
  output logic [ENTRIES-1:0][HDL_W-1:0]   ent_handle
);
  // Only valid flags are reset; payload fields are plain registers.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic sel;
    assign sel = we && (idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) ent_valid[i] <= 1'b0;
      else if (sel) ent_valid[i] <= wr_valid;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        ent_id[i]     <= wr_id;
        ent_seq[i]    <= wr_seq;
        ent_handle[i] <= wr_handle;
      end
    end
  end

  assert_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
    we |=> (ent_valid[$past(idx)] == $past(wr_valid)));

  assert_write_handle_R7: assert property (@(posedge clk) disable iff (rst)
    we |=> (ent_handle[$past(idx)] == $past(wr_handle)));
endmodule

// File: rtl/bind_match.sv
module bind_match #(
  parameter int ENTRIES = bind_pkg::ENTRIES_DEF,
  parameter int ID_W    = 20,
  parameter int SEQ_W   = bind_pkg::SEQ_W_DEF
) (
  input  logic [ID_W-1:0]               key_id,
  input  logic [SEQ_W-1:0]              key_seq,
  input  logic [ENTRIES-1:0]            ent_valid,
  input  logic [ENTRIES-1:0][ID_W-1:0]  ent_id,
  input  logic [ENTRIES-1:0][SEQ_W-1:0] ent_seq,
  output logic [ENTRIES-1:0]            hit
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic id_eq, seq_eq;
    assign id_eq  = (ent_id[i]  == key_id);
    assign seq_eq = (ent_seq[i] == key_seq);
    assign hit[i] = ent_valid[i] && id_eq && seq_eq;
  end
endmodule

// File: rtl/bind_prio.sv
module bind_prio #(
  parameter int ENTRIES = bind_pkg::ENTRIES_DEF,
  parameter int HDL_W   = bind_pkg::HDL_W_DEF
) (
  input  logic [ENTRIES-1:0]            hit,
  input  logic [ENTRIES-1:0][HDL_W-1:0] ent_handle,
  output logic                          any_hit,
  output logic [HDL_W-1:0]              handle
);
  // Walk from the top down so the lowest matching index is written last.
  always_comb begin
    handle  = HDL_W'(bind_pkg::HANDLE_MISS);
    any_hit = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        handle  = ent_handle[i];
        any_hit = 1'b1;
      end
    end
  end

  always_comb begin
    if (!any_hit) assert_miss_handle_R4: assert (handle == HDL_W'(bind_pkg::HANDLE_MISS));
  end
endmodule

// File: rtl/bind_lookup.sv
module bind_lookup #(
  parameter int XLEN    = bind_pkg::XLEN_DEF,
  parameter int SEQ_W   = bind_pkg::SEQ_W_DEF,
  parameter int HDL_W   = bind_pkg::HDL_W_DEF,
  parameter int ENTRIES = bind_pkg::ENTRIES_DEF,
  localparam int ID_W   = XLEN - SEQ_W,
  localparam int PAY_W  = XLEN - HDL_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [XLEN-1:0]  req_key,
  input  logic [PAY_W-1:0] req_payload,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [ID_W-1:0]  cfg_id,
  input  logic [SEQ_W-1:0] cfg_seq,
  input  logic [HDL_W-1:0] cfg_handle,
  input  logic             cfg_valid,
  output logic             rsp_valid,
  output logic [XLEN-1:0]  rsp_word
);
  logic [ENTRIES-1:0]            ent_valid;
  logic [ENTRIES-1:0][ID_W-1:0]  ent_id;
  logic [ENTRIES-1:0][SEQ_W-1:0] ent_seq;
  logic [ENTRIES-1:0][HDL_W-1:0] ent_handle;
  logic [ENTRIES-1:0]            hit;
  logic                          any_hit;
  logic [HDL_W-1:0]              sel_handle;

  logic [ID_W-1:0]  key_id;
  logic [SEQ_W-1:0] key_seq;
  assign key_seq = req_key[SEQ_W-1:0];
  assign key_id  = req_key[XLEN-1:SEQ_W];

  bind_table #(.ENTRIES(ENTRIES), .ID_W(ID_W), .SEQ_W(SEQ_W), .HDL_W(HDL_W)) u_table (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx),
    .wr_id(cfg_id), .wr_seq(cfg_seq), .wr_handle(cfg_handle), .wr_valid(cfg_valid),
    .ent_valid(ent_valid), .ent_id(ent_id), .ent_seq(ent_seq), .ent_handle(ent_handle)
  );

  bind_match #(.ENTRIES(ENTRIES), .ID_W(ID_W), .SEQ_W(SEQ_W)) u_match (
    .key_id(key_id), .key_seq(key_seq),
    .ent_valid(ent_valid), .ent_id(ent_id), .ent_seq(ent_seq), .hit(hit)
  );

  bind_prio #(.ENTRIES(ENTRIES), .HDL_W(HDL_W)) u_prio (
    .hit(hit), .ent_handle(ent_handle), .any_hit(any_hit), .handle(sel_handle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_word  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_word <= {req_payload, sel_handle};
    end
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && $stable(rsp_word)));
  assert_payload_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_word[XLEN-1:HDL_W] == $past(req_payload)));
  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !any_hit) |=> (rsp_word[HDL_W-1:0] == '0));
  assert_single_winner_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $onehot(hit)) |=> (rsp_word[HDL_W-1:0] == $past(sel_handle)));
endmodule

// File: tb/sim_bind_lookup.sv
module sim_bind_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_key;
  logic [19:0] req_payload;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [19:0] cfg_id;
  logic [11:0] cfg_seq;
  logic [11:0] cfg_handle;
  logic        cfg_valid;
  logic        rsp_valid;
  logic [31:0] rsp_word;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bind_lookup u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_key(req_key),
    .req_payload(req_payload), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_id(cfg_id), .cfg_seq(cfg_seq), .cfg_handle(cfg_handle),
    .cfg_valid(cfg_valid), .rsp_valid(rsp_valid), .rsp_word(rsp_word)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: one queued expectation per valid response.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected response", rsp_word, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_word === e, t, rsp_word, e);
      end
    end
  end

  task automatic cfg_write(input int idx, input logic [19:0] id, input logic [11:0] seq,
                           input logic [11:0] hdl, input logic v);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_id = id; cfg_seq = seq;
    cfg_handle = hdl; cfg_valid = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input logic [19:0] id, input logic [11:0] seq,
                        input logic [19:0] pay, input logic [11:0] exp_hdl, input string tag);
    req_valid = 1'b1; req_key = {id, seq}; req_payload = pay;
    exp_q.push_back({pay, exp_hdl});
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_key = '0; req_payload = '0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_id = '0; cfg_seq = '0; cfg_handle = '0; cfg_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(rsp_valid === 1'b0, "R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    lookup(20'hABCDE, 12'd0, 20'h00005, 12'd0, "R1 empty table returns 0");
    @(negedge clk);

    cfg_write(3, 20'hABCDE, 12'd0, 12'd32, 1'b1);
    cfg_write(5, 20'hABCDE, 12'd1, 12'd34, 1'b1);
    cfg_write(7, 20'h12345, 12'd0, 12'd33, 1'b1);
    cfg_write(0, 20'h00001, 12'd0, 12'd1,  1'b1);

    // back-to-back lookups
    lookup(20'hABCDE, 12'd0, 20'h00000, 12'd32, "R2 id/seq hit");
    lookup(20'hABCDE, 12'd1, 20'h00000, 12'd34, "R5 same id other seq");
    lookup(20'h12345, 12'd0, 20'h00001, 12'd33, "R2 second identifier");
    lookup(20'h00001, 12'd0, 20'h00002, 12'd1,  "R2 fallback handle 1");
    lookup(20'hABCDE, 12'd2, 20'h00003, 12'd0,  "R4 seq mismatch miss");
    lookup(20'h12346, 12'd0, 20'h00004, 12'd0,  "R4 id mismatch miss");
    lookup(20'hABCDE, 12'd0, 20'hFFFFF, 12'd32, "R3 all-ones payload");
    lookup(20'hABCDE, 12'd1, 20'h45678, 12'd34, "R3 mixed payload");
    repeat (2) @(negedge clk);
    check(rsp_valid === 1'b0, "R8 idle rsp_valid low", {31'b0, rsp_valid}, 32'h0);
    check(rsp_word === 32'h45678022, "R8 rsp_word held", rsp_word, 32'h45678022);

    cfg_write(10, 20'h55555, 12'd7, 12'd40, 1'b1);
    cfg_write(2,  20'h55555, 12'd7, 12'd41, 1'b1);
    lookup(20'h55555, 12'd7, 20'h00010, 12'd41, "R6 lowest index wins");
    cfg_write(2,  20'h55555, 12'd7, 12'd41, 1'b0);
    lookup(20'h55555, 12'd7, 20'h00011, 12'd40, "R9 invalidated entry skipped");

    // R7: write and lookup sampled at the same edge
    cfg_we = 1'b1; cfg_idx = 4'd10; cfg_id = 20'h55555; cfg_seq = 12'd7;
    cfg_handle = 12'd50; cfg_valid = 1'b1;
    lookup(20'h55555, 12'd7, 20'h00012, 12'd40, "R7 same-edge sees old entry");
    cfg_we = 1'b0;
    lookup(20'h55555, 12'd7, 20'h00013, 12'd50, "R7 next lookup sees new entry");

    cfg_write(15, 20'hFFFFF, 12'hFFF, 12'hFFF, 1'b1);
    lookup(20'hFFFFF, 12'hFFF, 20'h0ABCD, 12'hFFF, "R10 last slot full handle");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8 all responses arrived", exp_q.size(), 32'h0);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) check(1'b0, "watchdog expired", cyc, WATCHDOG);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule